// File: doc/BRIEF.md
# Cartridge DMA Control Register File

This block is the register front end of a DMA controller that moves data between system RAM and a cartridge bus. Software programs a RAM address, a cartridge address and a transfer length through a 32-bit write port that carries a per-bit mask. The moment a length register is written, the block sends a one-cycle start strobe to the data-moving engine. The strobe is for RAM-to-cartridge when the read-length register is written and for cartridge-to-RAM when the write-length register is written. The engine takes the addresses and lengths from dedicated output ports.

Each register trims the merged write value in its own way. The status location works in both directions: a read returns the busy and interrupt flags, and a write is taken as a command. One command bit clears the pending interrupt and the other asks the engine to reset. A completion pulse from the engine clears the busy flag, sets the pending flag and raises a level interrupt toward the system interrupt controller.

Top module: `pdma_regfile`

## Requirements
- R1: After reset, the RAM address, cartridge address, status and bus-timing locations read 0. Both length locations read 0x0000007F. `irq`, both start strobes and `reset_cmd` are low.
- R2: A write to offset 0x00 stores ((old & ~mask) | (data & mask)) & 0x00FFFFFE.
- R3: A write to offset 0x04 stores the merged value with bit 0 forced to 0 when `cfg_unaligned` is low. When `cfg_unaligned` is high it stores all 32 merged bits.
- R4: Writes to offset 0x08 (read length) and offset 0x0C (write length) keep only the low 24 merged bits.
- R5: A write to offset 0x08 drives `start_to_cart` high for exactly the one cycle after the write edge. A write to offset 0x0C does the same with `start_to_ram`. Either write sets the busy flag.
- R6: A read of offset 0x10 returns busy in bit 0, I/O busy in bit 1 (always 0), error in bit 2 (always 0) and interrupt pending in bit 3. Bits 31..4 read 0.
- R7: A `dma_done` pulse clears busy (unless a launch happens in the same cycle), sets pending and drives `irq` high from the next cycle on.
- R8: A write to offset 0x10 whose masked data has bit 1 set clears pending and `irq` in the next cycle. If its masked data has bit 0 set, `reset_cmd` is high for one cycle. A status write changes no other register.
- R9: When `dma_done` and a clear command occur in the same cycle, pending and `irq` stay set.
- R10: A write to offset 0x14 keeps only the low 8 merged bits, which also appear on `bus_timing`.
- R11: Reads of offsets 0x18 and 0x1C return 0. Writes to those offsets change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_unaligned | input | 1 | Keep bit 0 of the cartridge address |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write mask, 1 = update |
| rd_addr | input | 5 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| dma_done | input | 1 | Transfer-complete pulse from the engine |
| ram_addr | output | 32 | RAM address register |
| cart_addr | output | 32 | Cartridge address register |
| to_cart_len | output | 32 | Read-length register (RAM to cartridge) |
| to_ram_len | output | 32 | Write-length register (cartridge to RAM) |
| bus_timing | output | 8 | Bus-timing register |
| start_to_cart | output | 1 | Start strobe, RAM to cartridge |
| start_to_ram | output | 1 | Start strobe, cartridge to RAM |
| reset_cmd | output | 1 | Reset command strobe to the engine |
| irq | output | 1 | Level interrupt request |

## Verification
The bench writes all-ones and partial masks to find registers whose trim mask is wrong. Such a design would leave bit 0 or the top byte set in an address, or more than 24 bits in a length. It toggles `cfg_unaligned` around a cartridge write with an odd address, which exposes a design that ignores that input. It fires a completion pulse and a clear command in the same cycle; a design that gives the clear priority would drop the interrupt. It also writes to unmapped offsets, which catches a decoder that aliases them onto real registers. Strobe timing is checked cycle by cycle, so a strobe that is missing, lasts two cycles or goes out in the wrong direction is reported.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int NREG     = 6;
  localparam int IDX_RAM  = 0;
  localparam int IDX_CART = 1;
  localparam int IDX_RLEN = 2;
  localparam int IDX_WLEN = 3;
  localparam int IDX_STAT = 4;
  localparam int IDX_TIM  = 5;

  localparam int ST_BUSY = 0;
  localparam int ST_IO   = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_PEND = 3;
  localparam int CMD_RST = 0;
  localparam int CMD_CLR = 1;

  function automatic logic [31:0] merge(input logic [31:0] old_v,
                                        input logic [31:0] data,
                                        input logic [31:0] mask);
    return (old_v & ~mask) | (data & mask);
  endfunction

  function automatic logic [31:0] low_ones(input int n);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++)
      if (b < n) r[b] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] reg_keep(input int idx, input logic unaligned,
                                           input int ram_w, input int len_w,
                                           input int tim_w);
    case (idx)
      IDX_RAM:  return low_ones(ram_w) & ~32'h1;
      IDX_CART: return unaligned ? 32'hFFFF_FFFF : ~32'h1;
      IDX_RLEN, IDX_WLEN: return low_ones(len_w);
      IDX_TIM:  return low_ones(tim_w);
      default:  return '0;
    endcase
  endfunction

  function automatic logic [31:0] reg_reset(input int idx, input logic [31:0] len_rst);
    return (idx == IDX_RLEN || idx == IDX_WLEN) ? len_rst : 32'h0;
  endfunction
endpackage

// File: rtl/pdma_wr_decode.sv
module pdma_wr_decode #(
  parameter int ADDR_W = 5,
  parameter int NREG   = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = wr_en && (wr_addr == ADDR_W'(i * 4));
  end
endmodule

// File: rtl/pdma_field_reg.sv
module pdma_field_reg #(
  parameter logic [31:0] RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] data,
  input  logic [31:0] mask,
  input  logic [31:0] keep,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST;
    else if (we) q <= pdma_pkg::merge(q, data, mask) & keep;
  end
endmodule

// File: rtl/pdma_status.sv
module pdma_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_rlen,
  input  logic       hit_wlen,
  input  logic       hit_stat,
  input  logic [1:0] cmd,
  input  logic       dma_done,
  output logic       busy_q,
  output logic       pend_q,
  output logic       clr_evt,
  output logic       launch_evt,
  output logic       start_to_cart,
  output logic       start_to_ram,
  output logic       reset_cmd
);
  assign clr_evt    = hit_stat && cmd[pdma_pkg::CMD_CLR];
  assign launch_evt = hit_rlen || hit_wlen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      pend_q        <= 1'b0;
      start_to_cart <= 1'b0;
      start_to_ram  <= 1'b0;
      reset_cmd     <= 1'b0;
    end else begin
      start_to_cart <= hit_rlen;
      start_to_ram  <= hit_wlen;
      reset_cmd     <= hit_stat && cmd[pdma_pkg::CMD_RST];
      if (launch_evt)    busy_q <= 1'b1;
      else if (dma_done) busy_q <= 1'b0;
      if (dma_done)      pend_q <= 1'b1;
      else if (clr_evt)  pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pdma_regfile.sv
module pdma_regfile #(
  parameter int          ADDR_W  = 5,
  parameter int          RAM_W   = 24,
  parameter int          LEN_W   = 24,
  parameter int          TIM_W   = 8,
  parameter logic [31:0] LEN_RST = 32'h0000_007F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_unaligned,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       wr_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              dma_done,
  output logic [31:0]       ram_addr,
  output logic [31:0]       cart_addr,
  output logic [31:0]       to_cart_len,
  output logic [31:0]       to_ram_len,
  output logic [TIM_W-1:0]  bus_timing,
  output logic              start_to_cart,
  output logic              start_to_ram,
  output logic              reset_cmd,
  output logic              irq
);
  import pdma_pkg::*;

  logic [NREG-1:0] hit;
  logic [31:0]     regs [NREG];
  logic [31:0]     cmd_word;
  logic            busy_q, pend_q, clr_evt, launch_evt;

  assign cmd_word = wr_data & wr_mask;

  pdma_wr_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .hit(hit)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == IDX_STAT) begin : g_stat
      assign regs[i] = {28'h0, pend_q, 1'b0, 1'b0, busy_q};
    end else begin : g_field
      logic [31:0] keep;
      assign keep = reg_keep(i, cfg_unaligned, RAM_W, LEN_W, TIM_W);
      pdma_field_reg #(.RST(reg_reset(i, LEN_RST))) u_fr (
        .clk(clk), .rst_n(rst_n), .we(hit[i]), .data(wr_data),
        .mask(wr_mask), .keep(keep), .q(regs[i])
      );
    end
  end

  pdma_status u_st (
    .clk(clk), .rst_n(rst_n),
    .hit_rlen(hit[IDX_RLEN]), .hit_wlen(hit[IDX_WLEN]), .hit_stat(hit[IDX_STAT]),
    .cmd(cmd_word[1:0]), .dma_done(dma_done),
    .busy_q(busy_q), .pend_q(pend_q), .clr_evt(clr_evt), .launch_evt(launch_evt),
    .start_to_cart(start_to_cart), .start_to_ram(start_to_ram), .reset_cmd(reset_cmd)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i * 4)) rd_data = regs[i];
  end

  assign ram_addr    = regs[IDX_RAM];
  assign cart_addr   = regs[IDX_CART];
  assign to_cart_len = regs[IDX_RLEN];
  assign to_ram_len  = regs[IDX_WLEN];
  assign bus_timing  = regs[IDX_TIM][TIM_W-1:0];
  assign irq         = pend_q;
endmodule

// File: rtl/pdma_regfile_chk.sv
module pdma_regfile_chk #(
  parameter int ADDR_W = 5,
  parameter int LEN_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              st_busy,
  input logic              st_pend,
  input logic              dma_done,
  input logic [31:0]       ram_addr,
  input logic [31:0]       to_cart_len,
  input logic              start_to_cart,
  input logic              start_to_ram,
  input logic              irq,
  input logic              busy_q,
  input logic              clr_evt,
  input logic              launch_evt
);
  // R5
  launch_cart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(8)) |=> start_to_cart);
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_to_cart && start_to_ram));
  // R7
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> irq);
  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_done && !launch_evt) |=> !busy_q);
  // R8
  clr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !dma_done) |=> !irq);
  // R9
  done_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && dma_done) |=> irq);
  // R6
  stat_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(16)) |-> (st_pend == irq && st_busy == busy_q));
  // R2
  ram_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_addr & ~32'h00FF_FFFE) == 32'h0);
  // R4
  len_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_cart_len >> LEN_W) == 32'h0);
endmodule

bind pdma_regfile pdma_regfile_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
  .st_busy(rd_data[0]), .st_pend(rd_data[3]), .dma_done(dma_done),
  .ram_addr(ram_addr), .to_cart_len(to_cart_len), .start_to_cart(start_to_cart),
  .start_to_ram(start_to_ram), .irq(irq), .busy_q(busy_q), .clr_evt(clr_evt),
  .launch_evt(launch_evt)
);

// File: tb/tb_pdma_regfile.sv
`timescale 1ns/1ps
module tb_pdma_regfile;
  logic        clk = 0, rst_n = 0, cfg_unaligned = 0, wr_en = 0, dma_done = 0;
  logic [4:0]  wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, wr_mask = 0, rd_data;
  logic [31:0] ram_addr, cart_addr, to_cart_len, to_ram_len;
  logic [7:0]  bus_timing;
  logic        start_to_cart, start_to_ram, reset_cmd, irq;

  int checks = 0, errors = 0;
  bit finished = 0;

  typedef struct { int sel; logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  pdma_regfile dut (
    .clk(clk), .rst_n(rst_n), .cfg_unaligned(cfg_unaligned), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .dma_done(dma_done), .ram_addr(ram_addr),
    .cart_addr(cart_addr), .to_cart_len(to_cart_len), .to_ram_len(to_ram_len),
    .bus_timing(bus_timing), .start_to_cart(start_to_cart),
    .start_to_ram(start_to_ram), .reset_cmd(reset_cmd), .irq(irq)
  );

  // sel: 0 rd_data, 1 irq, 2 start_to_cart, 3 start_to_ram, 4 reset_cmd, 5 bus_timing
  task automatic expect_rd(input logic [4:0] a, input logic [31:0] e, input string t);
    rd_addr = a;
    q.push_back('{0, e, t});
  endtask
  task automatic expect_sig(input int s, input logic [31:0] e, input string t);
    q.push_back('{s, e, t});
  endtask
  task automatic settle();
    @(negedge clk); #1;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        0: act = rd_data;
        1: act = {31'h0, irq};
        2: act = {31'h0, start_to_cart};
        3: act = {31'h0, start_to_ram};
        4: act = {31'h0, reset_cmd};
        default: act = {24'h0, bus_timing};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [31:0] m,
                    input logic with_done = 1'b0);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d; wr_mask = m; dma_done = with_done;
    @(posedge clk); #1;
    wr_en = 0; dma_done = 0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1; dma_done = 1;
    @(posedge clk); #1; dma_done = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_rd(5'h00, 32'h0, "R1 ram addr"); expect_sig(1, 0, "R1 irq");
    expect_sig(2, 0, "R1 start_to_cart"); expect_sig(3, 0, "R1 start_to_ram");
    expect_sig(4, 0, "R1 reset_cmd"); settle();
    expect_rd(5'h04, 32'h0, "R1 cart addr"); settle();
    expect_rd(5'h08, 32'h7F, "R1 read len"); settle();
    expect_rd(5'h0C, 32'h7F, "R1 write len"); settle();
    expect_rd(5'h10, 32'h0, "R1 status"); settle();
    expect_rd(5'h14, 32'h0, "R1 timing"); settle();

    // R2 RAM address trimming
    wr(5'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    expect_rd(5'h00, 32'h00FF_FFFE, "R2 full write"); settle();
    wr(5'h00, 32'h0, 32'h0000_FF00);
    expect_rd(5'h00, 32'h00FF_00FE, "R2 masked write"); settle();

    // R3 cartridge alignment
    wr(5'h04, 32'h1234_5679, 32'hFFFF_FFFF);
    expect_rd(5'h04, 32'h1234_5678, "R3 aligned"); settle();
    cfg_unaligned = 1;
    wr(5'h04, 32'hABCD_EF01, 32'hFFFF_FFFF);
    expect_rd(5'h04, 32'hABCD_EF01, "R3 unaligned"); settle();
    cfg_unaligned = 0;

    // R5 / R4 read-length launch
    wr(5'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    expect_sig(2, 1, "R5 start_to_cart pulse"); expect_sig(3, 0, "R5 no start_to_ram");
    expect_rd(5'h08, 32'h00FF_FFFF, "R4 read len trim"); settle();
    expect_sig(2, 0, "R5 start_to_cart one cycle");
    expect_rd(5'h10, 32'h1, "R6 busy set"); settle();

    // R7 completion
    pulse_done();
    expect_sig(1, 1, "R7 irq raised");
    expect_rd(5'h10, 32'h8, "R7 busy clear pend set"); settle();

    // R8 clear
    wr(5'h10, 32'h2, 32'hFFFF_FFFF);
    expect_sig(1, 0, "R8 irq cleared"); expect_sig(4, 0, "R8 no reset_cmd");
    expect_rd(5'h10, 32'h0, "R8 status cleared"); settle();
    // clear bit masked off has no effect
    pulse_done();
    wr(5'h10, 32'h2, 32'hFFFF_FFFD);
    expect_sig(1, 1, "R8 masked clear ignored"); settle();
    wr(5'h10, 32'h2, 32'hFFFF_FFFF);
    wr(5'h10, 32'h1, 32'hFFFF_FFFF);
    expect_sig(4, 1, "R8 reset_cmd pulse");
    expect_rd(5'h00, 32'h00FF_00FE, "R8 other regs kept"); settle();
    expect_sig(4, 0, "R8 reset_cmd one cycle"); settle();

    // R5 / R4 write-length launch
    wr(5'h0C, 32'h0100_0010, 32'hFFFF_FFFF);
    expect_sig(3, 1, "R5 start_to_ram pulse"); expect_sig(2, 0, "R5 no start_to_cart");
    expect_rd(5'h0C, 32'h0000_0010, "R4 write len trim"); settle();

    // R9 completion and clear together
    wr(5'h10, 32'h2, 32'hFFFF_FFFF, 1'b1);
    expect_sig(1, 1, "R9 irq kept");
    expect_rd(5'h10, 32'h8, "R9 pend kept busy clear"); settle();

    // R10 timing
    wr(5'h14, 32'h0000_1234, 32'hFFFF_FFFF);
    expect_rd(5'h14, 32'h34, "R10 timing trim"); expect_sig(5, 32'h34, "R10 bus_timing"); settle();

    // R11 unmapped
    wr(5'h18, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    expect_sig(2, 0, "R11 no strobe"); expect_sig(3, 0, "R11 no strobe ram");
    expect_rd(5'h18, 32'h0, "R11 read 0x18"); settle();
    expect_rd(5'h1C, 32'h0, "R11 read 0x1C"); settle();
    expect_rd(5'h00, 32'h00FF_00FE, "R11 ram kept"); settle();
    expect_rd(5'h14, 32'h34, "R11 timing kept"); settle();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule